// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit holds the control registers of a 32-bit RISC core and sequences exception entry and return. Each cycle it takes the interrupt request lines, strobes for a software trap, an unimplemented instruction and an exception return, a control-register access port, the address of the next instruction and the current content of the exception return register. From these it decides whether the core must change flow and where to.

An exception is decided combinationally in the cycle its cause is present. In that cycle the unit drives the redirect target and the value for the exception return register. The register updates (saving status, leaving user mode, masking interrupts) land on the following clock edge. An exception return restores the saved status on that same kind of edge. Control-register reads are combinational. Writes take effect on the clock edge.

Top module: `exc_ctl_unit`

## Requirements
- R1: After reset, status, saved exception status, saved break status and the interrupt-enable mask are all zero, so the core is in supervisor mode (user_mode=0) with interrupts off (int_en=0).
- R2: Control register index 0 is status, 1 saved exception status, 2 saved break status, 3 interrupt-enable mask, 4 pending mask and 5 CPU identifier. In status, bit 0 is interrupt enable and bit 1 is user mode (1 = user). All other status bits read zero, and indices 6 and 7 read zero.
- R3: Pending bit k reads as 1 exactly when irq[k] is high and enable bit k is 1.
- R4: An interrupt exception (exc_cause=1) is raised only when interrupt enable is 1 and at least one pending bit is set.
- R5: In a cycle with an exception, redirect=1, redirect_pc = MEM_BASE+0x20, ea_we=1 and ea_wdata = next_pc. After the next edge, the saved exception status holds the previous status and both user mode and interrupt enable are 0.
- R6: exc_cause encodes 0 none, 1 interrupt, 2 trap, 3 unimplemented instruction. The order of priority is interrupt, then trap, then unimplemented. Any exception overrides an exception return in the same cycle.
- R7: An exception return without an exception drives redirect=1 and redirect_pc = ret_addr with ea_we=0. After the next edge, status equals the saved exception status.
- R8: In user mode, control reads return zero and control writes change nothing.
- R9: Writes to index 4 or 5 are ignored, and index 5 always reads the CPU_ID parameter.
- R10: The saved break status holds bits [1:0] as written and reads zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | NIRQ | Interrupt request lines |
| trap_req | input | 1 | Software trap strobe |
| unimp_req | input | 1 | Unimplemented-instruction strobe |
| eret_req | input | 1 | Exception-return strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_idx | input | 3 | Control register index |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read data (combinational) |
| next_pc | input | 32 | Address of the next instruction |
| ret_addr | input | 32 | Current exception return register value |
| redirect | output | 1 | Flow change this cycle |
| redirect_pc | output | 32 | Target of the flow change |
| ea_we | output | 1 | Write enable for the exception return register |
| ea_wdata | output | 32 | Value for the exception return register |
| exc_cause | output | 2 | Cause of the exception taken this cycle |
| user_mode | output | 1 | Current user-mode bit |
| int_en | output | 1 | Current interrupt-enable bit |

## Verification
Redirect, cause, return-register write and read data are due in the same cycle as their stimulus. The bench therefore drives on the falling edge and samples one nanosecond later, well before the next rising edge. Status and mask changes from entry, return or writes are due one rising edge later, so the bench checks them at the following falling edge through user_mode, int_en or a control read. Cause-priority probes are driven and withdrawn inside one low phase, so no entry is committed.

// File: rtl/exc_ctl_unit.sv
module exc_ctl_unit #(
  parameter logic [31:0] MEM_BASE = 32'h0000_0000,
  parameter logic [31:0] CPU_ID   = 32'h0000_00A5,
  parameter int          NIRQ     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq,
  input  logic            trap_req,
  input  logic            unimp_req,
  input  logic            eret_req,
  input  logic            ctl_wr,
  input  logic [2:0]      ctl_idx,
  input  logic [31:0]     ctl_wdata,
  output logic [31:0]     ctl_rdata,
  input  logic [31:0]     next_pc,
  input  logic [31:0]     ret_addr,
  output logic            redirect,
  output logic [31:0]     redirect_pc,
  output logic            ea_we,
  output logic [31:0]     ea_wdata,
  output logic [1:0]      exc_cause,
  output logic            user_mode,
  output logic            int_en
);
  localparam logic [31:0] HANDLER = MEM_BASE + 32'h20;

  logic            u, pie, eu, epie, bu, bpie;
  logic [NIRQ-1:0] ien;

  wire [NIRQ-1:0] pend    = irq & ien;
  wire            irq_hit = pie && (|pend);

  assign exc_cause = irq_hit   ? 2'd1 :
                     trap_req  ? 2'd2 :
                     unimp_req ? 2'd3 : 2'd0;

  wire take    = exc_cause != 2'd0;
  wire do_eret = eret_req && !take;
  wire wr_ok   = ctl_wr && !u;

  assign redirect    = take || do_eret;
  assign redirect_pc = take ? HANDLER : ret_addr;
  assign ea_we       = take;
  assign ea_wdata    = next_pc;
  assign user_mode   = u;
  assign int_en      = pie;

  always_comb begin
    ctl_rdata = '0;
    if (!u) begin
      case (ctl_idx)
        3'd0: ctl_rdata = {30'd0, u, pie};
        3'd1: ctl_rdata = {30'd0, eu, epie};
        3'd2: ctl_rdata = {30'd0, bu, bpie};
        3'd3: ctl_rdata = 32'(ien);
        3'd4: ctl_rdata = 32'(pend);
        3'd5: ctl_rdata = CPU_ID;
        default: ctl_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u <= 1'b0; pie <= 1'b0;
      eu <= 1'b0; epie <= 1'b0;
      bu <= 1'b0; bpie <= 1'b0;
      ien <= '0;
    end else begin
      if (take) begin
        eu <= u; epie <= pie;
        u <= 1'b0; pie <= 1'b0;
      end else begin
        if (do_eret) begin
          u <= eu; pie <= epie;
        end else if (wr_ok && ctl_idx == 3'd0) begin
          u <= ctl_wdata[1]; pie <= ctl_wdata[0];
        end
        if (wr_ok && ctl_idx == 3'd1) begin
          eu <= ctl_wdata[1]; epie <= ctl_wdata[0];
        end
      end
      if (wr_ok && ctl_idx == 3'd2) begin
        bu <= ctl_wdata[1]; bpie <= ctl_wdata[0];
      end
      if (wr_ok && ctl_idx == 3'd3) ien <= ctl_wdata[NIRQ-1:0];
    end
  end

  AST_ENTRY_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!user_mode && !int_en));  // R5
  AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ({eu, epie} == $past({u, pie})));  // R5
  AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !redirect_pc[0] && !ea_we) |=> ({user_mode, int_en} == $past({eu, epie})));  // R7
  AST_USER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && user_mode && !redirect) |=> ($stable(user_mode) && $stable(int_en) && $stable(ien)));  // R8
  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_idx == 3'd4 && !user_mode) |-> ((ctl_rdata & ~32'(ien)) == 32'd0));  // R3
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cause == 2'd1) |-> (int_en && (|irq)));  // R4
endmodule

// File: tb/exc_ctl_unit_bench.sv
module exc_ctl_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0000_0000;
  localparam logic [31:0] ID   = 32'h0000_00A5;
  localparam logic [31:0] HND  = 32'h0000_0020;

  logic clk = 0, rst_n = 0;
  logic [31:0] irq = 0;
  logic trap_req = 0, unimp_req = 0, eret_req = 0, ctl_wr = 0;
  logic [2:0] ctl_idx = 0;
  logic [31:0] ctl_wdata = 0, next_pc = 32'h0000_1000, ret_addr = 0;
  logic [31:0] ctl_rdata, redirect_pc, ea_wdata;
  logic redirect, ea_we, user_mode, int_en;
  logic [1:0] exc_cause;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_ctl_unit #(.MEM_BASE(BASE), .CPU_ID(ID), .NIRQ(32)) u_exc_ctl_unit (
    .clk(clk), .rst_n(rst_n), .irq(irq), .trap_req(trap_req), .unimp_req(unimp_req),
    .eret_req(eret_req), .ctl_wr(ctl_wr), .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .next_pc(next_pc), .ret_addr(ret_addr), .redirect(redirect),
    .redirect_pc(redirect_pc), .ea_we(ea_we), .ea_wdata(ea_wdata), .exc_cause(exc_cause),
    .user_mode(user_mode), .int_en(int_en));

  // {enable mask, irq lines, expected pending}
  localparam logic [95:0] VEC [8] = '{
    {32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_FFFF, 32'hA5A5_A5A5, 32'h0000_A5A5},
    {32'h8000_0001, 32'h8000_0001, 32'h8000_0001},
    {32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000},
    {32'hAAAA_AAAA, 32'hFFFF_0000, 32'hAAAA_0000},
    {32'h0000_0010, 32'h0000_0010, 32'h0000_0010},
    {32'h5555_5555, 32'h3333_3333, 32'h1111_1111}};

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk); ctl_wr = 1; ctl_idx = idx; ctl_wdata = d;
    @(posedge clk); #1 ctl_wr = 0;
  endtask

  task automatic peek(logic [2:0] idx, output logic [31:0] v);
    @(negedge clk); ctl_idx = idx; #1 v = ctl_rdata;
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 user_mode", 32'(user_mode), 0);
    chk("R1 int_en", 32'(int_en), 0);
    peek(3'd3, v); chk("R1 ienable", v, 0);
    peek(3'd1, v); chk("R1 estatus", v, 0);
    peek(3'd0, v); chk("R1 status", v, 0);

    for (int i = 0; i < 8; i++) begin
      wr(3'd3, VEC[i][95:64]);
      @(negedge clk); irq = VEC[i][63:32]; ctl_idx = 3'd4; #1;
      chk("R3 pending", ctl_rdata, VEC[i][31:0]);
      chk("R4 no irq with IE off", 32'(exc_cause), 0);
      irq = 0;
    end

    wr(3'd3, 32'h0000_0004);
    wr(3'd0, 32'hFFFF_FFFD);
    peek(3'd0, v); chk("R2 status bits", v, 32'h1);
    peek(3'd6, v); chk("R2 index 6", v, 0);
    wr(3'd2, 32'hFFFF_FFFE);
    peek(3'd2, v); chk("R10 bstatus", v, 32'h2);
    peek(3'd5, v); chk("R9 cpuid", v, ID);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    peek(3'd5, v); chk("R9 cpuid after write", v, ID);
    peek(3'd4, v); chk("R9 pending after write", v, 0);
    peek(3'd3, v); chk("R9 ienable kept", v, 32'h4);

    @(negedge clk); irq = 32'h8; #1;
    chk("R4 unmasked line ignored", 32'(redirect), 0);
    irq = 32'h4; #1;
    chk("R4 cause irq", 32'(exc_cause), 1);
    chk("R5 redirect", 32'(redirect), 1);
    chk("R5 handler", redirect_pc, HND);
    chk("R5 ea_we", 32'(ea_we), 1);
    chk("R5 ea_wdata", ea_wdata, 32'h0000_1000);
    @(negedge clk); irq = 0; #1;
    chk("R5 supervisor", 32'(user_mode), 0);
    chk("R5 ie cleared", 32'(int_en), 0);
    peek(3'd1, v); chk("R5 estatus saved", v, 32'h1);

    @(negedge clk); irq = 32'h4; #1;
    chk("R4 IE off blocks irq", 32'(exc_cause), 0);
    irq = 0;

    @(negedge clk); ret_addr = 32'h0000_1234; eret_req = 1; #1;
    chk("R7 redirect", 32'(redirect), 1);
    chk("R7 target", redirect_pc, 32'h0000_1234);
    chk("R7 no ea write", 32'(ea_we), 0);
    @(posedge clk); #1 eret_req = 0;
    @(negedge clk); #1;
    chk("R7 ie restored", 32'(int_en), 1);

    @(negedge clk); irq = 32'h4; trap_req = 1; eret_req = 1; #1;
    chk("R6 irq beats trap", 32'(exc_cause), 1);
    chk("R6 exception beats eret", redirect_pc, HND);
    irq = 0; eret_req = 0; unimp_req = 1; #1;
    chk("R6 trap beats unimp", 32'(exc_cause), 2);
    trap_req = 0; #1;
    chk("R6 unimp", 32'(exc_cause), 3);
    unimp_req = 0;

    wr(3'd1, 32'h3);
    @(negedge clk); eret_req = 1;
    @(posedge clk); #1 eret_req = 0;
    @(negedge clk); #1;
    chk("R7 user entered", 32'(user_mode), 1);
    peek(3'd0, v); chk("R8 read hidden", v, 0);
    peek(3'd5, v); chk("R8 cpuid hidden", v, 0);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    @(negedge clk); #1;
    chk("R8 status kept", 32'(int_en), 1);
    irq = 32'h4; #1;
    chk("R8 ienable kept", 32'(exc_cause), 1);
    @(negedge clk); irq = 0; #1;
    chk("R5 back to supervisor", 32'(user_mode), 0);
    peek(3'd1, v); chk("R5 user status saved", v, 32'h3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule